// File: doc/BRIEF.md
# Serial Wiper Register Target with Timed Nonvolatile Commit

This block is a two-wire serial bus target (I2C) placed in front of three byte registers. The first is a volatile wiper setting, which drives the `wiper_o` output. The second is a nonvolatile copy of that setting. The third is a commit-control register that decides whether a wiper write is also made persistent. The block answers one fixed seven-bit device identity. It accepts single-byte writes and random reads. A random read sets the register pointer with a write header, then issues a repeated START and a read header.

When a byte is written to the wiper and the control register holds zero, the closing STOP starts a commit. While the commit runs, the block ignores SCL and SDA entirely for `NV_CYCLES` system clocks. At the end of that time it copies the wiper value into nonvolatile storage. The nonvolatile copy is a plain register with a power-up value, and it is not cleared by reset. A reset reloads the wiper from it.

Top module: `i2c_wiper_target`

## Requirements
- R1: The identity byte 0x50 (device identity 0101000 in bits 7..1, bit 0 = 0 for write) and 0x51 (bit 0 = 1 for read) are acknowledged. Any other identity byte gets no ACK, and the block ignores the bus until the next START.
- R2: A write of START, 0x50, address 0x00, one data byte, STOP is acknowledged on all three bytes, and `wiper_o` then shows the data byte.
- R3: Writing to address 0x02 sets the commit-control register, and reading address 0x02 returns that value.
- R4: A register changes only on the SCL falling edge after the eighth data bit. A data byte cut short by STOP after seven bits leaves every register unchanged.
- R5: If the commit-control register is 0x00, a STOP that follows a wiper write starts a commit. `nv_o` takes the wiper value no earlier than `NV_CYCLES` clocks after STOP, and it changes at no other time.
- R6: If the commit-control register is nonzero, a wiper write updates only `wiper_o`, and `nv_o` keeps its value.
- R7: During a commit, SDA is never pulled low and all bus activity is ignored. A complete write sent during the commit gets no ACK and changes no register.
- R8: A random read (write header, address, repeated START, 0x51) returns the addressed register MSB first. It keeps returning that register for each byte the controller ACKs, and it releases SDA after the controller's NACK.
- R9: Addresses other than 0x00 and 0x02 read as 0x00. Writes to those addresses are acknowledged and discarded.
- R10: Reset sets the commit-control register to 0x00 and loads the wiper from the nonvolatile copy.
- R11: SDA is pulled low by the block only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| wiper_o | output | 8 | Current volatile wiper setting |
| nv_o | output | 8 | Nonvolatile wiper copy |

## Verification
The hardest condition to reach from the ports is a bus transaction that arrives while a commit is still running. The block must neither ACK it nor latch any part of it. The bench starts a full write as soon as the STOP that triggered a commit has been sent. It then checks for a missing ACK and unchanged outputs, and only afterwards waits for `nv_o` to update. Register loading on the LSB falling edge is tested with a data byte cut off by STOP after seven bits. Reset reload is tested by leaving the wiper different from the nonvolatile copy and then pulsing reset.

// File: rtl/i2c_wiper_target.sv
`timescale 1ns/1ps
module i2c_wiper_target #(
  parameter logic [6:0] DEV_ID    = 7'b0101000,
  parameter int         NV_CYCLES = 1000,
  parameter logic [7:0] NV_INIT   = 8'h80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] wiper_o,
  output logic [7:0] nv_o
);
  localparam int TW = $clog2(NV_CYCLES + 1);
  typedef enum logic [2:0] {P_IDLE, P_ID, P_ADDR, P_WR, P_RD, P_NV} phase_t;

  logic [2:0] scl_sy, sda_sy;
  phase_t     phase;
  logic [3:0] cnt;
  logic       in_ack, rw, rack, wr_pend;
  logic [7:0] shreg, tx, addr, acr, wiper;
  logic [TW-1:0] timer;
  logic [7:0] nv_q = NV_INIT;

  wire scl_s = scl_sy[1], scl_p = scl_sy[2];
  wire sda_s = sda_sy[1], sda_p = sda_sy[2];
  wire start_ev = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
  wire rise     = scl_s & ~scl_p;
  wire fall     = ~scl_s & scl_p;
  wire [7:0] rdval = (addr == 8'h00) ? wiper : (addr == 8'h02) ? acr : 8'h00;

  assign wiper_o = wiper;
  assign nv_o    = nv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sy <= 3'b111;
      sda_sy <= 3'b111;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
    end
  end

  always_ff @(posedge clk)
    if (phase == P_NV && timer == '0) nv_q <= wiper;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= P_IDLE; cnt <= '0; in_ack <= 1'b0; rw <= 1'b0; rack <= 1'b0;
      wr_pend <= 1'b0; shreg <= '0; tx <= '0; addr <= '0; acr <= '0;
      wiper <= nv_q; timer <= '0; sda_oe <= 1'b0;
    end else if (phase == P_NV) begin
      if (timer == '0) phase <= P_IDLE;
      else timer <= timer - 1'b1;
    end else if (start_ev) begin
      phase <= P_ID; cnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0; wr_pend <= 1'b0;
    end else if (stop_ev) begin
      sda_oe <= 1'b0; in_ack <= 1'b0; wr_pend <= 1'b0;
      if (wr_pend && acr == 8'h00) begin
        phase <= P_NV;
        timer <= TW'(NV_CYCLES - 1);
      end else phase <= P_IDLE;
    end else if (fall && phase != P_IDLE) begin
      if (!in_ack && cnt == 4'd8) begin
        in_ack <= 1'b1;
        case (phase)
          P_ID: begin
            if (shreg[7:1] == DEV_ID) begin
              sda_oe <= 1'b1; rw <= shreg[0];
            end else begin
              phase <= P_IDLE; in_ack <= 1'b0; sda_oe <= 1'b0;
            end
          end
          P_ADDR: begin addr <= shreg; sda_oe <= 1'b1; end
          P_WR: begin
            sda_oe <= 1'b1;
            if (addr == 8'h00) begin wiper <= shreg; wr_pend <= 1'b1; end
            else if (addr == 8'h02) acr <= shreg;
          end
          default: sda_oe <= 1'b0;
        endcase
      end else if (in_ack) begin
        in_ack <= 1'b0; cnt <= '0;
        case (phase)
          P_ID: begin
            if (rw) begin phase <= P_RD; tx <= rdval; sda_oe <= ~rdval[7]; end
            else begin phase <= P_ADDR; sda_oe <= 1'b0; end
          end
          P_ADDR: begin phase <= P_WR; sda_oe <= 1'b0; end
          P_RD: begin
            if (rack) begin tx <= rdval; sda_oe <= ~rdval[7]; end
            else begin phase <= P_IDLE; sda_oe <= 1'b0; end
          end
          default: sda_oe <= 1'b0;
        endcase
      end else if (phase == P_RD && cnt < 4'd8) begin
        sda_oe <= ~tx[3'd7 - cnt[2:0]];
      end
    end else if (rise && phase != P_IDLE) begin
      if (!in_ack && cnt < 4'd8) begin
        shreg <= {shreg[6:0], sda_s};
        cnt <= cnt + 1'b1;
      end else if (in_ack && phase == P_RD) rack <= ~sda_s;
    end
  end

  a_r11_oe_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  a_r7_nv_released: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_NV) |-> !sda_oe);
  a_r7_nv_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_NV) |=> ($stable(wiper) && $stable(acr)));
  a_r5_nv_only_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(nv_q) |-> $past(phase == P_NV));
  a_r6_acr_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ev && phase != P_NV && acr != 8'h00) |=> (phase != P_NV));
  a_r1_bad_id: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && phase == P_ID && !in_ack && cnt == 4'd8 && shreg[7:1] != DEV_ID)
      |=> (!sda_oe && phase == P_IDLE));
endmodule

// File: tb/i2c_wiper_target_tb.sv
`timescale 1ns/1ps
module i2c_wiper_target_tb;
  localparam int NV = 1000;
  localparam int Q  = 10;
  localparam logic [7:0] NV0 = 8'h80;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [7:0] wiper_o, nv_o;
  wire sda_line = sda_m & ~sda_oe;
  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_wiper, exp_acr, exp_nv;

  always #2 clk = ~clk;

  i2c_wiper_target #(.NV_CYCLES(NV), .NV_INIT(NV0)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .wiper_o(wiper_o), .nv_o(nv_o));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp_v);
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; qw(); scl = 1'b1; qw(); sda_m = 1'b0; qw(); scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; qw(); scl = 1'b1; qw(); scl = 1'b0; qw();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; qw(); scl = 1'b1; qw(); ack = ~sda_line; scl = 1'b0; qw();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qw(); scl = 1'b1; qw(); b[i] = sda_line; scl = 1'b0; qw();
    end
    sda_m = ~give_ack; qw(); scl = 1'b1; qw(); scl = 1'b0; qw(); sda_m = 1'b1;
  endtask

  function automatic logic [7:0] f_rd(input logic [7:0] a);
    if (a == 8'h00) return exp_wiper;
    if (a == 8'h02) return exp_acr;
    return 8'h00;
  endfunction

  task automatic do_write(input string req, input logic [7:0] a, input logic [7:0] d,
                          input bit wait_commit);
    logic k1, k2, k3;
    bus_start(); send_byte(8'h50, k1); send_byte(a, k2); send_byte(d, k3); bus_stop();
    chk({req, " id ack"}, {7'd0, k1}, 8'd1);
    chk({req, " addr ack"}, {7'd0, k2}, 8'd1);
    chk({req, " data ack"}, {7'd0, k3}, 8'd1);
    if (a == 8'h00) begin
      exp_wiper = d;
      if (exp_acr == 8'h00 && wait_commit) begin
        repeat (NV + 20) @(negedge clk);
        exp_nv = d;
      end
    end else if (a == 8'h02) exp_acr = d;
  endtask

  task automatic do_read(input string req, input logic [7:0] a, input int n);
    logic k1, k2, k3;
    logic [7:0] b;
    bus_start(); send_byte(8'h50, k1); send_byte(a, k2);
    bus_start(); send_byte(8'h51, k3);
    chk({req, " rd id ack"}, {7'd0, k3}, 8'd1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      chk({req, " read data"}, b, f_rd(a));
    end
    qw();
    chk({req, " sda released after NACK"}, {7'd0, sda_oe}, 8'd0);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic k;
    logic [7:0] d, a;
    void'($urandom(32'd7741));
    exp_nv = NV0; exp_wiper = NV0; exp_acr = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10 reset wiper", wiper_o, NV0);
    chk("R10 reset sda", {7'd0, sda_oe}, 8'd0);
    do_read("R10 reset acr", 8'h02, 1);

    // R1 bad identity
    bus_start(); send_byte(8'h52, k); chk("R1 bad id no ack", {7'd0, k}, 8'd0);
    send_byte(8'h00, k); chk("R1 ignored after bad id", {7'd0, k}, 8'd0);
    send_byte(8'h11, k); bus_stop();
    chk("R1 wiper untouched", wiper_o, exp_wiper);

    // R2 / R5 wiper write with commit
    do_write("R2", 8'h00, 8'h5A, 1'b1);
    chk("R2 wiper", wiper_o, 8'h5A);
    chk("R5 nv committed", nv_o, 8'h5A);

    // R4 truncated data byte
    bus_start(); send_byte(8'h50, k); send_byte(8'h00, k);
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    bus_stop();
    repeat (NV + 20) @(negedge clk);
    chk("R4 partial byte wiper", wiper_o, 8'h5A);
    chk("R4 partial byte nv", nv_o, 8'h5A);

    // R7 bus ignored during commit
    do_write("R7 trigger", 8'h00, 8'hC3, 1'b0);
    bus_start(); send_byte(8'h50, k);
    chk("R7 no ack while busy", {7'd0, k}, 8'd0);
    send_byte(8'h02, k); send_byte(8'h77, k); bus_stop();
    chk("R7 nv not yet", nv_o, 8'h5A);
    repeat (NV + 20) @(negedge clk);
    exp_nv = 8'hC3;
    chk("R7 wiper kept", wiper_o, 8'hC3);
    chk("R5 nv after commit", nv_o, 8'hC3);
    do_read("R7 acr untouched", 8'h02, 1);

    // R3 / R6 control register gates commit
    do_write("R3", 8'h02, 8'h01, 1'b1);
    do_read("R3 readback", 8'h02, 1);
    do_write("R6", 8'h00, 8'h3C, 1'b1);
    repeat (NV + 20) @(negedge clk);
    chk("R6 wiper volatile", wiper_o, 8'h3C);
    chk("R6 nv unchanged", nv_o, 8'hC3);

    // R8 multi-byte read, R9 unimplemented
    do_read("R8", 8'h00, 3);
    do_write("R9", 8'h01, 8'hFF, 1'b1);
    do_read("R9 unimpl", 8'h01, 2);
    chk("R9 wiper after unimpl write", wiper_o, 8'h3C);

    // R10 reset reloads wiper from nv
    rst_n = 1'b0; repeat (4) @(negedge clk); rst_n = 1'b1; repeat (4) @(negedge clk);
    exp_wiper = exp_nv; exp_acr = 8'h00;
    chk("R10 wiper reload", wiper_o, 8'hC3);
    do_read("R10 acr cleared", 8'h02, 1);

    // random mix
    for (int it = 0; it < 30; it++) begin
      a = 8'($urandom_range(0, 3));
      if ($urandom_range(0, 1) == 0) begin
        d = 8'($urandom);
        if (a == 8'h02 && $urandom_range(0, 1) == 0) d = 8'h00;
        do_write("R2 rand write", a, d, 1'b1);
        repeat (40) @(negedge clk);
        chk("R5 rand wiper", wiper_o, exp_wiper);
        chk("R6 rand nv", nv_o, exp_nv);
      end else begin
        do_read("R8 rand read", a, $urandom_range(1, 3));
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule